// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel LCD panel: a pixel strobe and a pixel clock divided down from the faster logic clock, horizontal and vertical sync, and a data-enable window. It also provides zero-based column and row indices for the visible area. Software programs four configuration words through a simple write port: a control word, a horizontal timing word, a vertical timing word, and a clock word that holds the pixel divider and the output polarity bits.

Each line runs through four phases in this order: sync, back porch, visible pixels, front porch. Each frame runs the same four phases in lines. The timing and clock words are latched into shadow copies when a frame starts, so rewriting them while the panel is being scanned takes effect at the next frame boundary. Clearing the enable bit does not stop the raster at once. The frame in progress runs to its last pixel. A single-cycle frame-done pulse then reports that the raster has stopped, so the timing can be changed safely.

Top module: `lcd_raster_timer`

## Requirements
- R1: Horizontal word (select 1) fields are: bits 9:0 = visible pixels minus one, bits 15:10 = sync width minus one, bits 23:16 = front porch minus one, bits 31:24 = back porch minus one. A line is sync, back porch, visible, front porch, and hsync is asserted only in the sync phase.
- R2: Vertical word (select 2) fields are: bits 9:0 = visible lines minus one, bits 15:10 = sync lines minus one, bits 23:16 = front porch lines and bits 31:24 = back porch lines, both as plain counts where zero means no line. vsync is asserted during the first sync lines of a frame.
- R3: Clock word (select 3) bits 7:0 hold the divider. pix_ce is high for one logic cycle every max(divider, floor) cycles, where floor is 2 in active-matrix mode and 3 in passive mode.
- R4: Control word (select 0) bit 0 is enable and bit 7 selects active-matrix mode. Setting enable while stopped starts a frame at pixel 0 of line 0, the first sync pixel.
- R5: After enable is cleared, the current frame still completes. frame_done is high for exactly one cycle, in the cycle after the frame's last pix_ce. The block then stays stopped, with no pix_ce and every output at its inactive level.
- R6: Clock word bits 20, 21, 22 and 23 invert hsync, vsync, pclk and de respectively. A set bit makes the signal active-low, and while stopped each of these outputs sits at the value of its bit.
- R7: The timing and clock words and the mode bit are sampled only at frame start. A write during a frame changes nothing until the next frame.
- R8: pix_cnt is the zero-based column while de is active, and 0 otherwise. line_cnt is the zero-based visible-line index during visible lines, and 0 otherwise.
- R9: Before polarity is applied, pclk is low in the first half of each pixel period (the first divider/2 cycles, rounded down) and high in the rest, so it is high in the cycle in which pix_ce is high.
- R10: After reset every configuration field is zero and the block is stopped: pix_ce, pclk, hsync, vsync, de, pix_cnt, line_cnt and frame_done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 control, 1 horizontal, 2 vertical, 3 clock/polarity |
| cfg_wdata | input | 32 | Configuration write data |
| pix_ce | output | 1 | One-cycle pixel strobe at the divided rate |
| pclk | output | 1 | Divided pixel clock, polarity applied |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable for visible pixels, polarity applied |
| pix_cnt | output | 10 | Visible column index |
| line_cnt | output | 10 | Visible line index |
| frame_done | output | 1 | One-cycle pulse when a requested stop takes effect |

## Verification
The bench builds the block with its default widths: 10-bit active fields, 6-bit sync fields, 8-bit porch fields and an 8-bit divider. Small programmed values then keep whole frames to a few hundred logic cycles. That makes it practical to check every pixel of several complete frames. The vectors cover both divider floors, a divider above the floor, zero-length vertical porches, one-pixel phases and mixed polarity settings. A back-to-back frame pair shows a timing write made mid-frame taking effect only at the next frame, and each stop request is followed through to the frame-done pulse and the stopped output levels.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  // configuration word selects
  localparam int SEL_CTRL = 0;
  localparam int SEL_HTIM = 1;
  localparam int SEL_VTIM = 2;
  localparam int SEL_CLK  = 3;
  // control word bits
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_TFT_BIT = 7;
  // timing word field offsets (shared by horizontal and vertical words)
  localparam int SW_LSB = 10;
  localparam int FP_LSB = 16;
  localparam int BP_LSB = 24;
  // clock word polarity field
  localparam int POL_LSB  = 20;
  localparam int POL_HS   = 0;
  localparam int POL_VS   = 1;
  localparam int POL_PCLK = 2;
  localparam int POL_DE   = 3;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;
endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tft,
  input  logic [DIV_W-1:0] div,
  output logic             pix_ce,
  output logic             pclk_raw
);
  localparam logic [DIV_W-1:0] FLOOR_AM = DIV_W'(2);
  localparam logic [DIV_W-1:0] FLOOR_PS = DIV_W'(3);

  logic [DIV_W-1:0] floor_v, eff, half, cnt_q, cnt_d;

  always_comb begin
    floor_v = tft ? FLOOR_AM : FLOOR_PS;
    eff     = (div < floor_v) ? floor_v : div;
    half    = eff >> 1;
  end

  assign pix_ce   = run && (cnt_q == eff - DIV_W'(1));
  assign pclk_raw = run && (cnt_q >= half);

  always_comb begin
    if (!run)        cnt_d = '0;
    else if (pix_ce) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: divided strobe never lasts two cycles (floor is at least 2)
  p_ce_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce);
  // R9: the clock is high whenever the strobe fires
  p_pclk_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |-> pclk_raw);
endmodule

// File: rtl/lcd_axis_seq.sv
module lcd_axis_seq #(
  parameter int POS_W = 11,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [POS_W-1:0] sync_len,
  input  logic [POS_W-1:0] back_len,
  input  logic [POS_W-1:0] act_len,
  input  logic [POS_W-1:0] front_len,
  output logic             sync,
  output logic             active,
  output logic             last,
  output logic [IDX_W-1:0] index
);
  logic [POS_W-1:0] pos_q, pos_d, act_start, act_end, total;

  always_comb begin
    act_start = sync_len + back_len;
    act_end   = act_start + act_len;
    total     = act_end + front_len;
  end

  assign last   = (pos_q == total - POS_W'(1));
  assign sync   = (pos_q < sync_len);
  assign active = (pos_q >= act_start) && (pos_q < act_end);
  assign index  = active ? IDX_W'(pos_q - act_start) : '0;

  always_comb begin
    if (clr)       pos_d = '0;
    else if (step) pos_d = last ? '0 : pos_q + POS_W'(1);
    else           pos_d = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // R1: position stays inside the programmed period
  p_pos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < total);
  // R4: a cleared axis restarts at the sync origin
  p_clr_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pos_q == '0));
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_raster_pkg::*;
#(
  parameter int ACT_W   = 10,
  parameter int SW_W    = 6,
  parameter int PORCH_W = 8,
  parameter int DIV_W   = 8,
  parameter int POL_W   = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              pix_ce,
  output logic              pclk,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [ACT_W-1:0]  pix_cnt,
  output logic [ACT_W-1:0]  line_cnt,
  output logic              frame_done
);
  localparam int GRP_W = ACT_W + SW_W + 2 * PORCH_W;
  localparam int CLK_W = DIV_W + POL_W;
  localparam int POS_W = $clog2((1 << ACT_W) + (1 << SW_W) + (2 << PORCH_W) + 1);
  localparam int O_SW  = ACT_W;
  localparam int O_FP  = ACT_W + SW_W;
  localparam int O_BP  = ACT_W + SW_W + PORCH_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  // configuration registers
  logic             en_q, en_d, tft_q, tft_d;
  logic [GRP_W-1:0] h_q, h_d, v_q, v_d, tim_word;
  logic [CLK_W-1:0] ck_q, ck_d;

  assign tim_word = {cfg_wdata[BP_LSB +: PORCH_W], cfg_wdata[FP_LSB +: PORCH_W],
                     cfg_wdata[SW_LSB +: SW_W], cfg_wdata[ACT_W-1:0]};

  always_comb begin
    en_d = en_q; tft_d = tft_q; h_d = h_q; v_d = v_q; ck_d = ck_q;
    if (cfg_we) begin
      if (cfg_sel == 2'(SEL_CTRL)) begin
        en_d  = cfg_wdata[CTL_EN_BIT];
        tft_d = cfg_wdata[CTL_TFT_BIT];
      end
      if (cfg_sel == 2'(SEL_HTIM)) h_d = tim_word;
      if (cfg_sel == 2'(SEL_VTIM)) v_d = tim_word;
      if (cfg_sel == 2'(SEL_CLK))
        ck_d = {cfg_wdata[POL_LSB +: POL_W], cfg_wdata[DIV_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q <= 1'b0; tft_q <= 1'b0; h_q <= '0; v_q <= '0; ck_q <= '0;
    end else begin
      en_q <= en_d; tft_q <= tft_d; h_q <= h_d; v_q <= v_d; ck_q <= ck_d;
    end
  end

  // run state and frame-start shadow copies
  run_state_e       st_q, st_d;
  logic             run, h_last, v_last, frame_end, frame_wrap, load_sh, done_d;
  logic             sh_tft;
  logic [GRP_W-1:0] sh_h, sh_v;
  logic [CLK_W-1:0] sh_ck;

  assign run        = (st_q == ST_RUN);
  assign frame_end  = pix_ce && h_last && v_last;
  assign frame_wrap = run && frame_end && en_q;
  assign load_sh    = !run || frame_wrap;
  assign done_d     = run && frame_end && !en_q;

  always_comb begin
    st_d = st_q;
    if (!run && en_q) st_d = ST_RUN;
    if (done_d)       st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= ST_IDLE; frame_done <= 1'b0;
      sh_tft <= 1'b0; sh_h <= '0; sh_v <= '0; sh_ck <= '0;
    end else begin
      st_q       <= st_d;
      frame_done <= done_d;
      if (load_sh) begin
        sh_tft <= tft_q; sh_h <= h_q; sh_v <= v_q; sh_ck <= ck_q;
      end
    end
  end

  // decoded lengths: horizontal all minus-one, vertical porches plain
  logic [POS_W-1:0] h_sw, h_bp, h_act, h_fp, v_sw, v_bp, v_act, v_fp;
  always_comb begin
    h_act = POS_W'(sh_h[ACT_W-1:0]) + POS_W'(1);
    h_sw  = POS_W'(sh_h[O_SW +: SW_W]) + POS_W'(1);
    h_fp  = POS_W'(sh_h[O_FP +: PORCH_W]) + POS_W'(1);
    h_bp  = POS_W'(sh_h[O_BP +: PORCH_W]) + POS_W'(1);
    v_act = POS_W'(sh_v[ACT_W-1:0]) + POS_W'(1);
    v_sw  = POS_W'(sh_v[O_SW +: SW_W]) + POS_W'(1);
    v_fp  = POS_W'(sh_v[O_FP +: PORCH_W]);
    v_bp  = POS_W'(sh_v[O_BP +: PORCH_W]);
  end

  logic             pclk_raw, h_sync, h_active, v_sync, v_active;
  logic [ACT_W-1:0] h_idx, v_idx;

  lcd_pix_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(srst_n), .run(run), .tft(sh_tft),
    .div(sh_ck[DIV_W-1:0]), .pix_ce(pix_ce), .pclk_raw(pclk_raw));

  lcd_axis_seq #(.POS_W(POS_W), .IDX_W(ACT_W)) u_hax (
    .clk(clk), .rst_n(srst_n), .clr(!run), .step(pix_ce),
    .sync_len(h_sw), .back_len(h_bp), .act_len(h_act), .front_len(h_fp),
    .sync(h_sync), .active(h_active), .last(h_last), .index(h_idx));

  lcd_axis_seq #(.POS_W(POS_W), .IDX_W(ACT_W)) u_vax (
    .clk(clk), .rst_n(srst_n), .clr(!run), .step(pix_ce && h_last),
    .sync_len(v_sw), .back_len(v_bp), .act_len(v_act), .front_len(v_fp),
    .sync(v_sync), .active(v_active), .last(v_last), .index(v_idx));

  // outputs with polarity
  logic             hs_raw, vs_raw, de_raw;
  logic [POL_W-1:0] pol;
  logic             unused_pol;
  assign pol        = sh_ck[DIV_W +: POL_W];
  assign unused_pol = ^pol[POL_W-1:POL_DE+1];
  assign hs_raw     = run && h_sync;
  assign vs_raw     = run && v_sync;
  assign de_raw     = run && h_active && v_active;

  assign hsync    = hs_raw   ^ pol[POL_HS];
  assign vsync    = vs_raw   ^ pol[POL_VS];
  assign pclk     = pclk_raw ^ pol[POL_PCLK];
  assign de       = de_raw   ^ pol[POL_DE];
  assign pix_cnt  = de_raw ? h_idx : '0;
  assign line_cnt = (run && v_active) ? v_idx : '0;

  // R1: visible data never overlaps a sync phase
  p_de_excl_sync_r1: assert property (@(posedge clk) disable iff (!srst_n)
    de_raw |-> (!hs_raw && !vs_raw));
  // R5: frame_done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!srst_n)
    frame_done |=> !frame_done);
  // R5: frame_done only follows a cleared enable
  p_done_cause_r5: assert property (@(posedge clk) disable iff (!srst_n)
    frame_done |-> !$past(en_q));
  // R5: a stopped raster produces no strobe and no data window
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!srst_n)
    !run |-> (!pix_ce && !de_raw));
  // R7: shadow timing holds for the whole frame
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (run && !frame_wrap) |=> ($stable(sh_h) && $stable(sh_v) && $stable(sh_ck)));
endmodule

// File: tb/lcd_raster_timer_tb_top.sv
`timescale 1ns/1ps
module lcd_raster_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_ce, pclk, hsync, vsync, de, frame_done;
  logic [9:0]  pix_cnt, line_cnt;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lcd_raster_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pix_ce(pix_ce), .pclk(pclk), .hsync(hsync),
    .vsync(vsync), .de(de), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .frame_done(frame_done));

  // stimulus / expectation table: timing words, mode bit, expected divider
  localparam int NV = 4;
  localparam logic [31:0] V_H [NV] = '{32'h0000_0003, 32'h0201_0404, 32'h0102_0002, 32'h0000_0805};
  localparam logic [31:0] V_V [NV] = '{32'h0100_0002, 32'h0001_0401, 32'h0202_0003, 32'h0000_0001};
  localparam logic [31:0] V_T [NV] = '{32'h0000_0001, 32'h0000_0000, 32'h00F0_0005, 32'h0050_0002};
  localparam bit          V_TFT [NV] = '{1'b1, 1'b0, 1'b0, 1'b0};
  localparam int          V_EFF [NV] = '{2, 3, 5, 3};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int htot(input logic [31:0] w);
    return int'(w[15:10]) + 1 + int'(w[31:24]) + 1 + int'(w[9:0]) + 1 + int'(w[23:16]) + 1;
  endfunction
  function automatic int vtot(input logic [31:0] w);
    return int'(w[15:10]) + 1 + int'(w[31:24]) + int'(w[9:0]) + 1 + int'(w[23:16]);
  endfunction

  // packed expectation {hs,vs,de,pix[9:0],line[9:0]} from R1, R2, R8
  function automatic int exp_vec(input logic [31:0] hw, input logic [31:0] vw, input int h, input int v);
    int hsl = int'(hw[15:10]) + 1;
    int hb  = int'(hw[31:24]) + 1;
    int ha  = int'(hw[9:0]) + 1;
    int vsl = int'(vw[15:10]) + 1;
    int vb  = int'(vw[31:24]);
    int va  = int'(vw[9:0]) + 1;
    bit hs  = h < hsl;
    bit vs  = v < vsl;
    bit ha_ok = (h >= hsl + hb) && (h < hsl + hb + ha);
    bit va_ok = (v >= vsl + vb) && (v < vsl + vb + va);
    int px  = (ha_ok && va_ok) ? h - (hsl + hb) : 0;
    int ln  = va_ok ? v - (vsl + vb) : 0;
    return (int'(hs) << 22) | (int'(vs) << 21) | (int'(ha_ok && va_ok) << 20) | (px << 10) | ln;
  endfunction

  // walk one frame strobe by strobe; optional single write at mid-frame
  task automatic run_frame(input logic [31:0] hw, input logic [31:0] vw, input logic [31:0] tw,
                           input int eff, input int mid_sel, input logic [31:0] mid_data,
                           input string tag);
    int total = htot(hw) * vtot(hw == hw ? vw : vw);
    int n = 0, h = 0, v = 0, cyc = 0, last_ce = 0;
    int mism = 0, per_bad = 0, clk_bad = 0, first_a = 0, first_e = 0, bad_per = 0;
    bit wrote = 0, pend = 0;
    total = htot(hw) * vtot(vw);
    while (n < total) begin
      @(negedge clk);
      cyc++;
      if (pend) begin cfg_we = 1'b0; pend = 0; end
      if (mid_sel >= 0 && !wrote && n == total / 2) begin
        cfg_we = 1'b1; cfg_sel = 2'(mid_sel); cfg_wdata = mid_data;
        wrote = 1; pend = 1;
      end
      if (pix_ce) begin
        int a = (int'(hsync ^ tw[20]) << 22) | (int'(vsync ^ tw[21]) << 21) |
                (int'(de ^ tw[23]) << 20) | (int'(pix_cnt) << 10) | int'(line_cnt);
        int e = exp_vec(hw, vw, h, v);
        if (a != e) begin
          if (mism == 0) begin first_a = a; first_e = e; end
          mism++;
        end
        if ((pclk ^ tw[22]) != 1'b1) clk_bad++;
        if (n > 0 && (cyc - last_ce) != eff) begin per_bad++; bad_per = cyc - last_ce; end
        last_ce = cyc;
        n++;
        h++;
        if (h == htot(hw)) begin h = 0; v++; end
      end
    end
    if (pend) begin @(negedge clk); cfg_we = 1'b0; end
    chk(mism == 0, {tag, " R1/R2/R4/R6/R8 raster"}, first_a, first_e);
    chk(per_bad == 0, {tag, " R3 strobe period"}, bad_per, eff);
    chk(clk_bad == 0, {tag, " R9 pclk high at strobe"}, clk_bad, 0);
  endtask

  // after a stop: pulse then quiet stopped state
  task automatic check_stop(input logic [31:0] tw, input string tag);
    int ces = 0, lv_bad = 0;
    if (cfg_we) ;
    @(negedge clk);
    chk(frame_done == 1'b1, {tag, " R5 frame_done pulse"}, int'(frame_done), 1);
    @(negedge clk);
    chk(frame_done == 1'b0, {tag, " R5 frame_done single cycle"}, int'(frame_done), 0);
    for (int i = 0; i < 12; i++) begin
      if (pix_ce) ces++;
      if (hsync != tw[20] || vsync != tw[21] || pclk != tw[22] || de != tw[23]) lv_bad++;
      @(negedge clk);
    end
    chk(ces == 0, {tag, " R5 no strobe after stop"}, ces, 0);
    chk(lv_bad == 0, {tag, " R6 stopped levels"}, lv_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk({pix_ce, pclk, hsync, vsync, de, frame_done} == 6'b0 && pix_cnt == 0 && line_cnt == 0,
        "R10 reset outputs", int'({pix_ce, pclk, hsync, vsync, de, frame_done}), 0);

    // table walk: program, enable, scan one frame, stop mid-frame
    for (int k = 0; k < NV; k++) begin
      string tg = $sformatf("vec%0d", k);
      wr(1, V_H[k]);
      wr(2, V_V[k]);
      wr(3, V_T[k]);
      wr(0, (32'(V_TFT[k]) << 7) | 32'h1);
      run_frame(V_H[k], V_V[k], V_T[k], V_EFF[k], 0, 32'(V_TFT[k]) << 7, tg);
      check_stop(V_T[k], tg);
    end

    // R7: horizontal rewrite mid-frame lands on the next frame only
    wr(1, V_H[0]);
    wr(2, V_V[0]);
    wr(3, V_T[0]);
    wr(0, 32'h81);
    run_frame(V_H[0], V_V[0], V_T[0], 2, 1, V_H[3], "R7 frame A keeps old");
    chk(frame_done == 1'b0, "R7 no stop between frames", int'(frame_done), 0);
    run_frame(V_H[3], V_V[0], V_T[0], 2, 0, 32'h80, "R7 frame B uses new");
    check_stop(V_T[0], "R7");

    // R3: passive floor with divider 1 and mode switch taking effect at start
    wr(3, 32'h0000_0001);
    wr(0, 32'h0000_0001);
    run_frame(V_H[3], V_V[0], 32'h0000_0001, 3, 0, 32'h0, "R3 passive div1");
    check_stop(32'h0000_0001, "R3 passive");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule